// File: doc/BRIEF.md
# Raster timing generator

This block produces the horizontal and vertical raster for a display controller running off the pixel clock. Software programs packed configuration words: horizontal and vertical extents, where each sync pulse starts, how wide it is and which level it is active at, the pixel format, the line pitch and a frame base byte address. From these the block runs a pixel counter and a line counter and derives display-enable, horizontal sync, vertical sync and the byte address of the frame-buffer line being shown.

Horizontal extents and the horizontal sync width are counted in 8-pixel character units. The horizontal sync start is in pixels. Vertical quantities are in lines. The per-line address starts at the frame base with its low three bits cleared. It then steps once per line by pitch × 8 × bytes-per-pixel, where bytes-per-pixel comes from the pixel format.

All configuration is held in a shadow copy. That copy is loaded in reset and, after reset, only at the first line of vertical blanking, so a displayed frame never mixes two setups.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is high at a clock edge, the pixel counter and the line counter become 0, `fetch_addr` becomes `cfg_base` with bits [2:0] cleared, and the current configuration inputs become the active setup.
- R2: `pix_x` advances by one per clock through (H+1)×8 pixels, where H = `cfg_h_extent[15:0]`, then returns to 0 while `line_y` advances by one. `line_y` returns to 0 after line V, where V = `cfg_v_extent[15:0]`.
- R3: `de` is high exactly when `pix_x`/8 ≤ `cfg_h_extent[31:16]` and `line_y` ≤ `cfg_v_extent[31:16]`.
- R4: The horizontal pulse covers pixels S ≤ `pix_x` < S + 8×W, with S = `cfg_h_sync[11:0]` and W = `cfg_h_sync[21:16]`. A W of 0 acts as 1. If `cfg_h_sync[23]` is set the pulse drives `hsync` low, otherwise high.
- R5: The vertical pulse covers lines T+1 ≤ `line_y` < T+1+W, with T = `cfg_v_sync[11:0]` and W = `cfg_v_sync[20:16]`. A W of 0 acts as 1. If `cfg_v_sync[23]` is set the pulse drives `vsync` low, otherwise high.
- R6: `cfg_ctrl[10:8]` selects the pixel format: 2 is 1 byte per pixel, 3 and 4 are 2 bytes per pixel, and 6 is 4 bytes per pixel.
- R7: On line 0 of every frame, `fetch_addr` equals the active base with bits [2:0] cleared. Each following line adds `cfg_pitch` × 8 × bytes-per-pixel, modulo 2^ADDR_W.
- R8: A setup whose format code is not 2, 3, 4 or 6 is rejected as a whole. The previous setup keeps running unchanged: same frame size, sync positions and addresses.
- R9: Outside reset, the active setup changes only on the clock edge that ends the last display line. Input changes made during the display lines of a frame do not affect those lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_h_extent | input | 32 | [15:0] total characters − 1, [31:16] displayed characters − 1 |
| cfg_h_sync | input | 32 | [11:0] sync start pixel, [21:16] width in characters, [23] active-low flag |
| cfg_v_extent | input | 32 | [15:0] total lines − 1, [31:16] displayed lines − 1 |
| cfg_v_sync | input | 32 | [11:0] sync start line − 1, [20:16] width in lines, [23] active-low flag |
| cfg_ctrl | input | 32 | [10:8] pixel format code |
| cfg_pitch | input | PITCH_W | Line pitch in 8-pixel units |
| cfg_base | input | ADDR_W | Frame base byte address |
| pix_x | output | 19 | Pixel position in the line |
| line_y | output | 16 | Line position in the frame |
| de | output | 1 | Display enable |
| hsync | output | 1 | Horizontal sync at the programmed level |
| vsync | output | 1 | Vertical sync at the programmed level |
| fetch_addr | output | ADDR_W | Byte address of the current line |

## Verification
The bench compares whole frames cycle by cycle against timing it derives from the requirements. The frames cover four pixel formats, both sync polarities, zero and maximum sync widths, and a vertical pulse that runs past the end of the frame.

A design that treated a zero width literally would never pulse. One that confused character and pixel units for the sync width would make the pulse eight times too short. One that stepped the address by pitch alone, or ignored the format, would walk the wrong line stride.

Two sequences target the shadow. A format code of 5 must leave the old frame running: a design that latched it would change the frame length. A mid-frame rewrite must not touch the remaining display lines: a design that latched immediately would move sync and stride partway down the picture.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int EXT_W     = 16;          // extent fields
    localparam int PIX_W     = EXT_W + 3;   // character count plus 3 sub-pixel bits
    localparam int SPOS_W    = 12;          // sync start fields
    localparam int HSW_W     = 6;           // horizontal sync width field
    localparam int VSW_W     = 5;           // vertical sync width field
    localparam int WID_LSB   = 16;
    localparam int POL_BIT   = 23;
    localparam int FMT_LSB   = 8;
    localparam int ALIGN_LSB = 3;           // base forced to 8-byte alignment

    typedef enum logic [2:0] {
        FMT_IDX8   = 3'd2,
        FMT_RGB555 = 3'd3,
        FMT_RGB565 = 3'd4,
        FMT_XRGB32 = 3'd6
    } pix_fmt_e;

    typedef struct packed {
        logic [EXT_W-1:0]  h_total_m1;
        logic [EXT_W-1:0]  h_disp_m1;
        logic [SPOS_W-1:0] hs_start;
        logic [HSW_W-1:0]  hs_width;
        logic              hs_low;
        logic [EXT_W-1:0]  v_total_m1;
        logic [EXT_W-1:0]  v_disp_m1;
        logic [SPOS_W-1:0] vs_start_m1;
        logic [VSW_W-1:0]  vs_width;
        logic              vs_low;
        pix_fmt_e          fmt;
    } timing_cfg_t;

    function automatic logic fmt_ok(input logic [2:0] code);
        return (code == 3'd2) || (code == 3'd3) || (code == 3'd4) || (code == 3'd6);
    endfunction

    // log2 of bytes per pixel
    function automatic logic [1:0] bpp_shift(input pix_fmt_e f);
        case (f)
            FMT_RGB555, FMT_RGB565: return 2'd1;
            FMT_XRGB32:             return 2'd2;
            default:                return 2'd0;
        endcase
    endfunction

    function automatic logic [HSW_W-1:0] clamp_hw(input logic [HSW_W-1:0] w);
        return (w == '0) ? HSW_W'(1) : w;
    endfunction

    function automatic logic [VSW_W-1:0] clamp_vw(input logic [VSW_W-1:0] w);
        return (w == '0) ? VSW_W'(1) : w;
    endfunction

endpackage

// File: rtl/raster_cfg_shadow.sv
module raster_cfg_shadow
    import raster_pkg::*;
#(
    parameter int PITCH_W = 10,
    parameter int ADDR_W  = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [31:0]         h_ext,
    input  logic [31:0]         h_sync,
    input  logic [31:0]         v_ext,
    input  logic [31:0]         v_sync,
    input  logic [31:0]         ctrl,
    input  logic [PITCH_W-1:0]  pitch_in,
    input  logic [ADDR_W-1:0]   base_in,
    output timing_cfg_t         cfg_q,
    output logic [PITCH_W-1:0]  pitch_q,
    output logic [ADDR_W-1:0]   base_q
);

    timing_cfg_t dec;
    timing_cfg_t rst_cfg;
    logic        cfg_ok;

    always_comb begin
        dec.h_total_m1  = h_ext[EXT_W-1:0];
        dec.h_disp_m1   = h_ext[WID_LSB +: EXT_W];
        dec.hs_start    = h_sync[SPOS_W-1:0];
        dec.hs_width    = clamp_hw(h_sync[WID_LSB +: HSW_W]);
        dec.hs_low      = h_sync[POL_BIT];
        dec.v_total_m1  = v_ext[EXT_W-1:0];
        dec.v_disp_m1   = v_ext[WID_LSB +: EXT_W];
        dec.vs_start_m1 = v_sync[SPOS_W-1:0];
        dec.vs_width    = clamp_vw(v_sync[WID_LSB +: VSW_W]);
        dec.vs_low      = v_sync[POL_BIT];
        dec.fmt         = pix_fmt_e'(ctrl[FMT_LSB +: 3]);
        cfg_ok          = fmt_ok(ctrl[FMT_LSB +: 3]);
        rst_cfg         = dec;
        if (!cfg_ok) rst_cfg.fmt = FMT_IDX8;
    end

    wire unused_bits = ^{h_sync[15:12], h_sync[22], h_sync[31:24],
                         v_sync[15:12], v_sync[22:21], v_sync[31:24],
                         ctrl[7:0], ctrl[31:11]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= rst_cfg;
            pitch_q <= pitch_in;
            base_q  <= base_in;
        end else if (load && cfg_ok) begin
            cfg_q   <= dec;
            pitch_q <= pitch_in;
            base_q  <= base_in;
        end
    end

endmodule

// File: rtl/raster_hcount.sv
module raster_hcount
    import raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [EXT_W-1:0]  total_m1,
    output logic [PIX_W-1:0]  pix_x,
    output logic              line_end
);

    assign line_end = (&pix_x[2:0]) && (pix_x[PIX_W-1:3] >= total_m1);

    always_ff @(posedge clk) begin
        if (rst || line_end) pix_x <= '0;
        else                 pix_x <= pix_x + PIX_W'(1);
    end

endmodule

// File: rtl/raster_vcount.sv
module raster_vcount
    import raster_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_end,
    input  logic [EXT_W-1:0]  total_m1,
    input  logic [EXT_W-1:0]  disp_m1,
    input  logic [ADDR_W-1:0] stride,
    input  logic [ADDR_W-1:0] rst_base,
    input  logic [ADDR_W-1:0] frame_base,
    output logic [EXT_W-1:0]  line_y,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              blank_start
);

    logic wrap;

    assign wrap        = (line_y >= total_m1);
    assign blank_start = line_end && (line_y == disp_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_y     <= '0;
            fetch_addr <= rst_base;
        end else if (line_end) begin
            if (wrap) begin
                line_y     <= '0;
                fetch_addr <= frame_base;
            end else begin
                line_y     <= line_y + EXT_W'(1);
                fetch_addr <= fetch_addr + stride;
            end
        end
    end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_pkg::*;
#(
    parameter int PITCH_W = 10,
    parameter int ADDR_W  = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [31:0]         cfg_h_extent,
    input  logic [31:0]         cfg_h_sync,
    input  logic [31:0]         cfg_v_extent,
    input  logic [31:0]         cfg_v_sync,
    input  logic [31:0]         cfg_ctrl,
    input  logic [PITCH_W-1:0]  cfg_pitch,
    input  logic [ADDR_W-1:0]   cfg_base,
    output logic [PIX_W-1:0]    pix_x,
    output logic [EXT_W-1:0]    line_y,
    output logic                de,
    output logic                hsync,
    output logic                vsync,
    output logic [ADDR_W-1:0]   fetch_addr
);

    localparam int VW = EXT_W + 1;

    timing_cfg_t         cfg_q;
    logic [PITCH_W-1:0]  pitch_q;
    logic [ADDR_W-1:0]   base_q;
    logic [ADDR_W-1:0]   base_al_in;
    logic [ADDR_W-1:0]   stride;
    logic                line_end;
    logic                blank_start;

    assign base_al_in = {cfg_base[ADDR_W-1:ALIGN_LSB], ALIGN_LSB'(0)};
    assign stride     = ADDR_W'({pitch_q, 3'b000}) << bpp_shift(cfg_q.fmt);

    raster_cfg_shadow #(.PITCH_W(PITCH_W), .ADDR_W(ADDR_W)) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .load     (blank_start),
        .h_ext    (cfg_h_extent),
        .h_sync   (cfg_h_sync),
        .v_ext    (cfg_v_extent),
        .v_sync   (cfg_v_sync),
        .ctrl     (cfg_ctrl),
        .pitch_in (cfg_pitch),
        .base_in  (base_al_in),
        .cfg_q    (cfg_q),
        .pitch_q  (pitch_q),
        .base_q   (base_q)
    );

    raster_hcount u_hcnt (
        .clk      (clk),
        .rst      (rst),
        .total_m1 (cfg_q.h_total_m1),
        .pix_x    (pix_x),
        .line_end (line_end)
    );

    raster_vcount #(.ADDR_W(ADDR_W)) u_vcnt (
        .clk         (clk),
        .rst         (rst),
        .line_end    (line_end),
        .total_m1    (cfg_q.v_total_m1),
        .disp_m1     (cfg_q.v_disp_m1),
        .stride      (stride),
        .rst_base    (base_al_in),
        .frame_base  (base_q),
        .line_y      (line_y),
        .fetch_addr  (fetch_addr),
        .blank_start (blank_start)
    );

    logic [PIX_W-1:0] hs_lo, hs_hi;
    logic [VW-1:0]    vs_lo, vs_hi, line_ext;
    logic             hs_on, vs_on;

    always_comb begin
        hs_lo    = PIX_W'(cfg_q.hs_start);
        hs_hi    = hs_lo + PIX_W'({cfg_q.hs_width, 3'b000});
        hs_on    = (pix_x >= hs_lo) && (pix_x < hs_hi);
        vs_lo    = VW'(cfg_q.vs_start_m1) + VW'(1);
        vs_hi    = vs_lo + VW'(cfg_q.vs_width);
        line_ext = VW'(line_y);
        vs_on    = (line_ext >= vs_lo) && (line_ext < vs_hi);
        hsync    = hs_on ^ cfg_q.hs_low;
        vsync    = vs_on ^ cfg_q.vs_low;
        de       = (pix_x[PIX_W-1:3] <= cfg_q.h_disp_m1) && (line_y <= cfg_q.v_disp_m1);
    end

endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk
    import raster_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic [PIX_W-1:0]  pix_x,
    input logic [EXT_W-1:0]  line_y,
    input logic              de,
    input logic [ADDR_W-1:0] fetch_addr,
    input timing_cfg_t       cfg_q
);

    logic last_disp_edge;
    assign last_disp_edge = (&pix_x[2:0]) && (pix_x[PIX_W-1:3] >= cfg_q.h_total_m1)
                            && (line_y == cfg_q.v_disp_m1);

    assert_x_step_R2: assert property (@(posedge clk) disable iff (rst)
        (pix_x != '0) |-> (pix_x == $past(pix_x) + PIX_W'(1)));

    assert_y_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (pix_x != '0) |-> $stable(line_y));

    assert_de_vblank_R3: assert property (@(posedge clk) disable iff (rst)
        (line_y > cfg_q.v_disp_m1) |-> !de);

    assert_addr_align_R7: assert property (@(posedge clk) disable iff (rst)
        fetch_addr[2:0] == 3'b000);

    assert_fmt_legal_R8: assert property (@(posedge clk) disable iff (rst)
        fmt_ok(cfg_q.fmt));

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !last_disp_edge |=> $stable(cfg_q));

endmodule

bind raster_timing_gen raster_timing_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pix_x      (pix_x),
    .line_y     (line_y),
    .de         (de),
    .fetch_addr (fetch_addr),
    .cfg_q      (cfg_q)
);

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;

    localparam int PITCH_W = 10;
    localparam int ADDR_W  = 24;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [31:0]        cfg_h_extent, cfg_h_sync, cfg_v_extent, cfg_v_sync, cfg_ctrl;
    logic [PITCH_W-1:0] cfg_pitch;
    logic [ADDR_W-1:0]  cfg_base;
    logic [18:0]        pix_x;
    logic [15:0]        line_y;
    logic               de, hsync, vsync;
    logic [ADDR_W-1:0]  fetch_addr;

    always #5 clk = ~clk;

    raster_timing_gen #(.PITCH_W(PITCH_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst),
        .cfg_h_extent(cfg_h_extent), .cfg_h_sync(cfg_h_sync),
        .cfg_v_extent(cfg_v_extent), .cfg_v_sync(cfg_v_sync),
        .cfg_ctrl(cfg_ctrl), .cfg_pitch(cfg_pitch), .cfg_base(cfg_base),
        .pix_x(pix_x), .line_y(line_y), .de(de), .hsync(hsync), .vsync(vsync),
        .fetch_addr(fetch_addr)
    );

    int n_checks = 0;
    int n_err    = 0;

    // expected active setup
    int e_htc, e_hdc, e_hs, e_hw, e_hneg, e_vt, e_vd, e_vs, e_vw, e_vneg, e_bytes, e_pitch;
    int e_base;

    task automatic check(input string req, input string ctx, input bit ok,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, ctx, act, exp);
        end
    endtask

    task automatic set_cfg(input int htc, hdc, hs, hw_raw, hneg, vt, vd, vs_field,
                           vw_raw, vneg, fmt, pitch, base, input bit take);
        cfg_h_extent = {16'(hdc - 1), 16'(htc - 1)};
        cfg_h_sync   = 32'(hs) | (32'(hw_raw) << 16) | (hneg != 0 ? 32'h0080_0000 : 32'h0);
        cfg_v_extent = {16'(vd - 1), 16'(vt - 1)};
        cfg_v_sync   = 32'(vs_field) | (32'(vw_raw) << 16) | (vneg != 0 ? 32'h0080_0000 : 32'h0);
        cfg_ctrl     = 32'(fmt) << 8;
        cfg_pitch    = PITCH_W'(pitch);
        cfg_base     = ADDR_W'(base);
        if (take) begin
            e_htc = htc; e_hdc = hdc; e_hs = hs; e_hw = (hw_raw == 0) ? 1 : hw_raw;
            e_hneg = hneg; e_vt = vt; e_vd = vd; e_vs = vs_field + 1;
            e_vw = (vw_raw == 0) ? 1 : vw_raw; e_vneg = vneg;
            e_bytes = (fmt == 2) ? 1 : (fmt == 6) ? 4 : 2;   // R6 byte sizes
            e_pitch = pitch; e_base = base & ~7;
        end
    endtask

    task automatic wait_frame_start();
        @(negedge clk);
        while (!(pix_x == '0 && line_y == '0)) @(negedge clk);
    endtask

    task automatic settle();
        wait_frame_start();
        wait_frame_start();
    endtask

    // Compare lines l0..l1 cycle by cycle; caller stands at x=0 of line l0.
    task automatic check_lines(input string ctx, input int l0, input int l1);
        int bad[5];
        longint fa[5], fe[5];
        int stride;
        stride = e_pitch * 8 * e_bytes;
        for (int k = 0; k < 5; k++) begin bad[k] = 0; fa[k] = 0; fe[k] = 0; end
        for (int y = l0; y <= l1; y++) begin
            for (int x = 0; x < e_htc * 8; x++) begin
                logic xd, xh, xv;
                int xa;
                xd = ((x / 8) <= e_hdc - 1) && (y <= e_vd - 1);
                xh = ((x >= e_hs) && (x < e_hs + 8 * e_hw)) ^ (e_hneg != 0);
                xv = ((y >= e_vs) && (y < e_vs + e_vw)) ^ (e_vneg != 0);
                xa = (e_base + y * stride) & ((1 << ADDR_W) - 1);
                if (int'(pix_x) != x || int'(line_y) != y) begin
                    if (bad[0] == 0) begin fa[0] = pix_x + 1000000 * line_y; fe[0] = x + 1000000 * y; end
                    bad[0]++;
                end
                if (de !== xd) begin
                    if (bad[1] == 0) begin fa[1] = de; fe[1] = xd; end
                    bad[1]++;
                end
                if (hsync !== xh) begin
                    if (bad[2] == 0) begin fa[2] = x; fe[2] = xh; end
                    bad[2]++;
                end
                if (vsync !== xv) begin
                    if (bad[3] == 0) begin fa[3] = y; fe[3] = xv; end
                    bad[3]++;
                end
                if (int'(fetch_addr) != xa) begin
                    if (bad[4] == 0) begin fa[4] = fetch_addr; fe[4] = xa; end
                    bad[4]++;
                end
                @(negedge clk);
            end
        end
        check("R2", {ctx, " position"}, bad[0] == 0, fa[0], fe[0]);
        check("R3", {ctx, " de"},       bad[1] == 0, fa[1], fe[1]);
        check("R4", {ctx, " hsync"},    bad[2] == 0, fa[2], fe[2]);
        check("R5", {ctx, " vsync"},    bad[3] == 0, fa[3], fe[3]);
        check("R7", {ctx, " fetch"},    bad[4] == 0, fa[4], fe[4]);
    endtask

    task automatic test_reset();
        set_cfg(12, 8, 72, 2, 0, 10, 6, 6, 2, 0, 4, 8, 'h1005, 1'b1);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "reset pix_x", pix_x == '0, pix_x, 0);
        check("R1", "reset line_y", line_y == '0, line_y, 0);
        check("R1", "reset fetch aligned", fetch_addr == 24'h1000, fetch_addr, 'h1000);
        check("R1", "reset sync idle", {hsync, vsync} == 2'b00, {hsync, vsync}, 0);
        rst = 1'b0;
        check_lines("R1 R6 16bpp first frame", 0, e_vt - 1);
    endtask

    task automatic test_32bpp_low_polarity();
        // zero widths clamp to one; both pulses active low
        set_cfg(10, 6, 56, 0, 1, 8, 5, 5, 0, 1, 6, 6, 'h2003, 1'b1);
        settle();
        check_lines("R6 32bpp clamp low-pol", 0, e_vt - 1);
    endtask

    task automatic test_8bpp_wide_sync();
        set_cfg(80, 8, 16, 63, 0, 6, 3, 3, 31, 1, 2, 8, 'h4000F, 1'b1);
        settle();
        check_lines("R6 8bpp max widths", 0, e_vt - 1);
    endtask

    task automatic test_15bpp();
        set_cfg(9, 7, 60, 1, 0, 7, 4, 4, 3, 0, 3, 7, 'h300, 1'b1);
        settle();
        check_lines("R6 15bpp", 0, e_vt - 1);
    endtask

    task automatic test_midframe_R9();
        wait_frame_start();
        while (!(line_y == 16'd2 && pix_x == '0)) @(negedge clk);
        set_cfg(12, 8, 72, 2, 0, 10, 6, 6, 2, 0, 4, 8, 'h1005, 1'b0);
        check_lines("R9 old setup holds on display lines", 2, e_vd - 1);
        set_cfg(12, 8, 72, 2, 0, 10, 6, 6, 2, 0, 4, 8, 'h1005, 1'b1);
        wait_frame_start();
        check_lines("R9 new setup next frame", 0, e_vt - 1);
    endtask

    task automatic test_bad_format_R8();
        set_cfg(14, 4, 8, 1, 1, 5, 2, 1, 1, 1, 5, 3, 'h7777, 1'b0);
        settle();
        check_lines("R8 format 5 rejected", 0, e_vt - 1);
        check("R8", "frame length unchanged", pix_x == '0 && line_y == '0,
              pix_x + 1000000 * line_y, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin : main
        test_reset();
        test_32bpp_low_polarity();
        test_8bpp_wide_sync();
        test_15bpp();
        test_midframe_R9();
        test_bad_format_R8();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule